// File: doc/BRIEF.md
# Configuration Image Header Parser

This block reads a configuration image one byte at a time, as it streams past, and pulls two numbers out of the image header. The first is the byte offset at which the bitstream payload begins. The second is the payload length in bytes. It never holds the whole image. It counts the bytes it accepts and keeps only the few header fields it needs in small registers.

The parse has three stages. First, a header-size byte gives the position of a record count and of a lookup table. Second, the table is made of fixed nine-byte records, and the parser walks it looking for two block kinds: one that locates the payload and one that locates a table of component sizes. Third, the parser unpacks that table. The table holds 22-bit component sizes laid end to end across byte boundaries. Each size counts 16-byte frames, and the parser adds them into a running byte total.

A `start` pulse rearms the block for a new image. At the end of a parse it gives either one `done` pulse with valid results, or a `parseErr` flag that stays up until the next `start`.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset, or in the cycle after `start`, `done`, `parseErr`, `dataSize` and `bitstreamStart` are all 0 and the byte index is back to 0. A byte offered in the same cycle as `start` is not counted.
- R2: The byte at index 24 is the header size H. Any value from 0 to 25 raises `parseErr`, because the record count would not lie after it in the stream.
- R3: The byte at index H−1 is the record count. A count of zero raises `parseErr`.
- R4: Records begin at index H and are 9 bytes each. Record byte 0 is the block kind, and record bytes 1 to 4 are a little-endian 32-bit start offset. Kind 8 sets `bitstreamStart`, kind 5 sets the component-table offset, and every other kind is skipped. The walk ends at the first record after which both kinds have been seen, in any order.
- R5: If either kind is still missing after the last record has been read, `parseErr` is raised.
- R6: When the walk ends, the component-table offset must be greater than 56, greater than the index of the byte that ended the walk, and smaller than `bitstreamStart`. Otherwise `parseErr` is raised instead of waiting.
- R7: The component count is a little-endian 16-bit value at indices 55 (low byte) and 56 (high byte). If the count is zero, `done` pulses after the byte at the table offset arrives, and `dataSize` is 0.
- R8: Component i occupies bits 22·i to 22·i+21 of the table, counted least-significant bit first from bit 0 of the first table byte. `dataSize` is 16 times the sum of all components, modulo 2^32.
- R9: `done` is high for exactly one cycle: the cycle after the byte that completes the last component. `done` and `parseErr` are never high together. After either one, further bytes change no output until `start`.
- R10: When `inValid` is low, the byte on `inData` is ignored and the byte index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Rearm for a new image; the byte index returns to 0 |
| inValid | input | 1 | `inData` carries the next image byte |
| inData | input | 8 | Image byte |
| bitstreamStart | output | 32 | Offset at which the payload begins |
| dataSize | output | 32 | Payload length in bytes |
| done | output | 1 | One-cycle pulse when the results are valid |
| parseErr | output | 1 | Header could not be parsed; held until `start` |

## Verification
The bench sweeps three header sizes, four lookup-table orders and a range of component counts. The table orders are: payload record first, component record first, an unrelated record in front, and an unrelated record between the two. These orders separate a walk that ends at the first match from one that ends at the wrong record, or that fails to skip unknown kinds. The component counts run from zero to two hundred, with the sizes set to the 22-bit maximum on every fifth index. This exposes wrong bit alignment in the packed table, and overflow of the 32-bit total. Odd counts are streamed with idle gaps carrying junk on `inData`, to show that the byte index holds still. Further images are corrupted one field at a time (header size, record count, a missing kind, a table that is too early or too late). Each must give an error and no `done` pulse.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int START_W = 32;
  localparam int NUM_W   = 16;

  typedef enum logic [2:0] {
    S_HDR,
    S_CNT,
    S_REC,
    S_WAIT,
    S_COMP,
    S_DONE,
    S_ERR
  } parse_state_e;

  typedef struct packed {
    logic clr;
    logic capHdr;
    logic capCnt;
    logic recByte;
    logic loadComp;
    logic compByte;
  } dp_strobe_t;

  typedef struct packed {
    logic atHdr;
    logic hdrBad;
    logic atCnt;
    logic byteZero;
    logic recEval;
    logic bothFound;
    logic orderOk;
    logic lastRec;
    logic atComp;
    logic compZero;
    logic compLast;
  } dp_status_t;

endpackage

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter int HDR_OFF     = 24,
  parameter int CNT_OFF     = 55,
  parameter int REC_BYTES   = 9,
  parameter int ID_BS       = 8,
  parameter int ID_COMP     = 5,
  parameter int COMP_BITS   = 22,
  parameter int FRAME_SHIFT = 4,
  parameter int ACC_W       = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [7:0]         inData,
  input  dp_strobe_t         stb,
  output dp_status_t         sts,
  output logic [START_W-1:0] bitstreamStart,
  output logic [ACC_W-1:0]   dataSize
);

  localparam int POS_W      = $clog2(REC_BYTES);
  localparam int START_LAST = 4;
  localparam int BUF_W      = COMP_BITS + 8;
  localparam int BITS_W     = $clog2(BUF_W + 1);
  localparam int MIN_HDR    = HDR_OFF + 2;

  logic [START_W-1:0] idx;
  logic [7:0]         hdrSize;
  logic [7:0]         recLeft;
  logic [NUM_W-1:0]   compCnt;
  logic [NUM_W-1:0]   compLeft;
  logic [POS_W-1:0]   recPos;
  logic [7:0]         recId;
  logic [23:0]        recOff;
  logic [START_W-1:0] bsStart;
  logic [START_W-1:0] compStart;
  logic               bsFound;
  logic               compFound;
  logic [BUF_W-1:0]   bitBuf;
  logic [BITS_W-1:0]  bitCnt;
  logic [ACC_W-1:0]   acc;

  logic [START_W-1:0] fullStart;
  logic               idIsBs;
  logic               idIsComp;
  logic [START_W-1:0] candBs;
  logic [START_W-1:0] candComp;
  logic [BUF_W-1:0]   newBuf;
  logic [BITS_W-1:0]  newCnt;
  logic               fieldReady;

  always_comb begin
    fullStart  = {inData, recOff};
    idIsBs     = (recId == 8'(ID_BS));
    idIsComp   = (recId == 8'(ID_COMP));
    candBs     = idIsBs ? fullStart : bsStart;
    candComp   = idIsComp ? fullStart : compStart;
    newBuf     = bitBuf | (BUF_W'(inData) << bitCnt);
    newCnt     = bitCnt + BITS_W'(8);
    fieldReady = (newCnt >= BITS_W'(COMP_BITS));

    sts.atHdr     = (idx == START_W'(HDR_OFF));
    sts.hdrBad    = (inData < 8'(MIN_HDR));
    sts.atCnt     = (idx == ({24'd0, hdrSize} - START_W'(1)));
    sts.byteZero  = (inData == 8'd0);
    sts.recEval   = (recPos == POS_W'(START_LAST));
    sts.bothFound = (bsFound | idIsBs) & (compFound | idIsComp);
    sts.orderOk   = (candComp > idx) && (candComp > START_W'(CNT_OFF + 1)) &&
                    (candComp < candBs);
    sts.lastRec   = (recLeft == 8'd1);
    sts.atComp    = (idx == compStart);
    sts.compZero  = (compCnt == '0);
    sts.compLast  = fieldReady && (compLeft == NUM_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx       <= '0;
      hdrSize   <= '0;
      recLeft   <= '0;
      compCnt   <= '0;
      compLeft  <= '0;
      recPos    <= '0;
      recId     <= '0;
      recOff    <= '0;
      bsStart   <= '0;
      compStart <= '0;
      bsFound   <= 1'b0;
      compFound <= 1'b0;
      bitBuf    <= '0;
      bitCnt    <= '0;
      acc       <= '0;
    end else if (stb.clr) begin
      idx       <= '0;
      hdrSize   <= '0;
      recLeft   <= '0;
      compCnt   <= '0;
      compLeft  <= '0;
      recPos    <= '0;
      recId     <= '0;
      recOff    <= '0;
      bsStart   <= '0;
      compStart <= '0;
      bsFound   <= 1'b0;
      compFound <= 1'b0;
      bitBuf    <= '0;
      bitCnt    <= '0;
      acc       <= '0;
    end else begin
      if (inValid) begin
        idx <= idx + START_W'(1);
        if (idx == START_W'(CNT_OFF))     compCnt[7:0]  <= inData;
        if (idx == START_W'(CNT_OFF + 1)) compCnt[15:8] <= inData;
      end
      if (stb.capHdr) hdrSize <= inData;
      if (stb.capCnt) recLeft <= inData;
      if (stb.recByte) begin
        recPos <= (recPos == POS_W'(REC_BYTES - 1)) ? '0 : recPos + POS_W'(1);
        case (recPos)
          POS_W'(0): recId          <= inData;
          POS_W'(1): recOff[7:0]    <= inData;
          POS_W'(2): recOff[15:8]   <= inData;
          POS_W'(3): recOff[23:16]  <= inData;
          default: ;
        endcase
        if (recPos == POS_W'(START_LAST)) begin
          if (idIsBs) begin
            bsStart <= fullStart;
            bsFound <= 1'b1;
          end
          if (idIsComp) begin
            compStart <= fullStart;
            compFound <= 1'b1;
          end
        end
        if (recPos == POS_W'(REC_BYTES - 1)) recLeft <= recLeft - 8'd1;
      end
      if (stb.loadComp) begin
        compLeft <= compCnt;
        bitBuf   <= BUF_W'(inData);
        bitCnt   <= BITS_W'(8);
      end else if (stb.compByte) begin
        if (fieldReady) begin
          acc      <= acc + (ACC_W'(newBuf[COMP_BITS-1:0]) << FRAME_SHIFT);
          bitBuf   <= newBuf >> COMP_BITS;
          bitCnt   <= newCnt - BITS_W'(COMP_BITS);
          compLeft <= compLeft - NUM_W'(1);
        end else begin
          bitBuf <= newBuf;
          bitCnt <= newCnt;
        end
      end
    end
  end

  assign bitstreamStart = bsStart;
  assign dataSize       = acc;

  AST_BITS_BELOW_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < BITS_W'(COMP_BITS)); // R8
  AST_IDX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !stb.clr) |=> $stable(idx)); // R10
  AST_HDR_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    stb.capHdr |=> (hdrSize >= 8'(MIN_HDR))); // R2
  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (acc == '0 && bsStart == '0)); // R1

endmodule

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       inValid,
  input  dp_status_t sts,
  output dp_strobe_t stb,
  output logic       done,
  output logic       parseErr
);

  parse_state_e state;
  parse_state_e nxt;

  always_comb begin
    stb = '0;
    nxt = state;
    if (start) begin
      stb.clr = 1'b1;
      nxt     = S_HDR;
    end else if (inValid) begin
      case (state)
        S_HDR: if (sts.atHdr) begin
          if (sts.hdrBad) nxt = S_ERR;
          else begin
            stb.capHdr = 1'b1;
            nxt        = S_CNT;
          end
        end
        S_CNT: if (sts.atCnt) begin
          if (sts.byteZero) nxt = S_ERR;
          else begin
            stb.capCnt = 1'b1;
            nxt        = S_REC;
          end
        end
        S_REC: begin
          stb.recByte = 1'b1;
          if (sts.recEval) begin
            if (sts.bothFound) nxt = sts.orderOk ? S_WAIT : S_ERR;
            else if (sts.lastRec) nxt = S_ERR;
          end
        end
        S_WAIT: if (sts.atComp) begin
          if (sts.compZero) nxt = S_DONE;
          else begin
            stb.loadComp = 1'b1;
            nxt          = S_COMP;
          end
        end
        S_COMP: begin
          stb.compByte = 1'b1;
          if (sts.compLast) nxt = S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_HDR;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (nxt == S_DONE) && (state != S_DONE);
    end
  end

  assign parseErr = (state == S_ERR);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && parseErr)); // R9
  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (parseErr && !start) |=> parseErr); // R9
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!parseErr && !done)); // R1

endmodule

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser
  import cfg_hdr_pkg::*;
#(
  parameter int HDR_OFF     = 24,
  parameter int CNT_OFF     = 55,
  parameter int REC_BYTES   = 9,
  parameter int ID_BS       = 8,
  parameter int ID_COMP     = 5,
  parameter int COMP_BITS   = 22,
  parameter int FRAME_SHIFT = 4,
  parameter int ACC_W       = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         inValid,
  input  logic [7:0]   inData,
  output logic [31:0]  bitstreamStart,
  output logic [31:0]  dataSize,
  output logic         done,
  output logic         parseErr
);

  dp_strobe_t stb;
  dp_status_t sts;
  logic [ACC_W-1:0] accOut;

  cfg_hdr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .sts      (sts),
    .stb      (stb),
    .done     (done),
    .parseErr (parseErr)
  );

  cfg_hdr_datapath #(
    .HDR_OFF     (HDR_OFF),
    .CNT_OFF     (CNT_OFF),
    .REC_BYTES   (REC_BYTES),
    .ID_BS       (ID_BS),
    .ID_COMP     (ID_COMP),
    .COMP_BITS   (COMP_BITS),
    .FRAME_SHIFT (FRAME_SHIFT),
    .ACC_W       (ACC_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .inValid        (inValid),
    .inData         (inData),
    .stb            (stb),
    .sts            (sts),
    .bitstreamStart (bitstreamStart),
    .dataSize       (accOut)
  );

  assign dataSize = 32'(accOut);

endmodule

// File: tb/cfg_hdr_parser_tb.sv
module cfg_hdr_parser_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic [31:0] bitstreamStart;
  logic [31:0] dataSize;
  logic        done;
  logic        parseErr;

  int checks = 0;
  int fails = 0;
  int doneSeen = 0;
  logic [7:0] img [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_hdr_parser u_dut (
    .clk            (clk),
    .rstN           (rstN),
    .start          (start),
    .inValid        (inValid),
    .inData         (inData),
    .bitstreamStart (bitstreamStart),
    .dataSize       (dataSize),
    .done           (done),
    .parseErr       (parseErr)
  );

  always @(negedge clk) if (rstN && done) doneSeen++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] compSize(int i, int seed);
    logic [31:0] t;
    if (((i + seed) % 5) == 0) return 22'h3FFFFF;
    t = 32'(i) * 32'h9E3779B1 + 32'(seed) * 32'd40503 + 32'd17;
    return t[27:6];
  endfunction

  task automatic putRec(int p, logic [7:0] id, logic [31:0] st);
    img[p]   = id;
    img[p+1] = st[7:0];
    img[p+2] = st[15:8];
    img[p+3] = st[23:16];
    img[p+4] = st[31:24];
  endtask

  // order 0: bs, comp, other   order 1: comp, bs
  // order 2: other, comp, bs   order 3: comp, other, bs
  task automatic buildGood(int h, int order, int n, int cs, int seed,
                           output int bs, output int len, output logic [31:0] expSize);
    int tab;
    int k;
    logic [21:0] sz;
    tab = (22 * n + 7) / 8;
    bs  = cs + tab + 3;
    len = bs + 2;
    k   = (order == 1) ? 2 : 3;
    for (int j = 0; j < 1024; j++) img[j] = 8'(j * 37 + seed * 11 + 1);
    img[24]  = 8'(h);
    img[h-1] = 8'(k);
    case (order)
      0: begin putRec(h, 8, bs); putRec(h+9, 5, cs); putRec(h+18, 7, 32'h1234); end
      1: begin putRec(h, 5, cs); putRec(h+9, 8, bs); end
      2: begin putRec(h, 3, 32'h40); putRec(h+9, 5, cs); putRec(h+18, 8, bs); end
      default: begin putRec(h, 5, cs); putRec(h+9, 9, 32'h77); putRec(h+18, 8, bs); end
    endcase
    img[55] = 8'(n);
    img[56] = 8'(n >> 8);
    for (int j = 0; j < tab; j++) img[cs+j] = 8'h00;
    expSize = 32'h0;
    for (int i = 0; i < n; i++) begin
      sz = compSize(i, seed);
      expSize = expSize + {6'd0, sz, 4'd0};
      for (int b = 0; b < 22; b++) begin
        int q;
        q = i * 22 + b;
        if (sz[b]) img[cs + q/8][q%8] = 1'b1;
      end
    end
  endtask

  task automatic runImage(int len, bit gap);
    doneSeen = 0;
    @(negedge clk);
    start = 1'b1;
    inValid = 1'b1;
    inData = 8'hEE;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < len; j++) begin
      if (gap && (j % 3 == 1)) begin
        inValid = 1'b0;
        inData = 8'hFF;
        @(negedge clk);
      end
      inValid = 1'b1;
      inData = img[j];
      @(negedge clk);
    end
    inValid = 1'b0;
    inData = 8'h00;
    repeat (3) @(negedge clk);
  endtask

  task automatic expectErr(string req, int len);
    runImage(len, 1'b0);
    chk(req, {31'd0, parseErr}, 32'd1);
    chk("R9 no done on error", doneSeen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int bs;
    int len;
    logic [31:0] expSize;
    int nList [8] = '{0, 1, 2, 3, 4, 5, 7, 11};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset done", {31'd0, done}, 32'd0);
    chk("R1 reset parseErr", {31'd0, parseErr}, 32'd0);
    chk("R1 reset dataSize", dataSize, 32'd0);
    chk("R1 reset bitstreamStart", bitstreamStart, 32'd0);

    for (int h = 26; h <= 28; h++) begin
      for (int order = 0; order < 4; order++) begin
        foreach (nList[ni]) begin
          int n;
          int cs;
          n  = nList[ni];
          cs = 64 + (n % 3) * 5;
          buildGood(h, order, n, cs, h + order + n, bs, len, expSize);
          runImage(len, n[0]);
          if (n == 0) chk("R7 zero count dataSize", dataSize, 32'd0);
          else chk("R8 dataSize", dataSize, expSize);
          chk("R4 bitstreamStart", bitstreamStart, 32'(bs));
          chk("R9 single done", doneSeen, 1);
          chk("R6 no parseErr", {31'd0, parseErr}, 32'd0);
          if (n[0]) chk("R10 gaps ignored", dataSize, expSize);
        end
      end
    end

    buildGood(27, 3, 200, 70, 0, bs, len, expSize);
    runImage(len, 1'b0);
    chk("R8 wrap dataSize", dataSize, expSize);
    chk("R9 wrap single done", doneSeen, 1);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    img[24] = 8'd0;
    expectErr("R2 header zero", len);
    runImage(0, 1'b0);
    chk("R1 start clears parseErr", {31'd0, parseErr}, 32'd0);
    chk("R1 start clears dataSize", dataSize, 32'd0);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    img[24] = 8'd25;
    expectErr("R2 header 25", len);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    img[25] = 8'd0;
    expectErr("R3 zero records", len);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    img[26 + 9] = 8'd7;
    expectErr("R5 missing payload kind", len);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    img[26] = 8'd6;
    expectErr("R5 missing table kind", len);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    putRec(26, 5, 32'd50);
    expectErr("R6 table before count", len);

    buildGood(26, 1, 4, 64, 5, bs, len, expSize);
    putRec(26, 5, 32'(bs));
    expectErr("R6 table not before payload", len);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule